// File: doc/BRIEF.md
# DMA Request Queue with Transfer ID Tracking

This block is the control and status front end of a single-channel DMA engine. Software fills a set of request registers (destination and source address, row length, row count, the two strides and a small flag field), then strikes a start register. The request enters a shallow queue and receives a 5-bit hardware ID. Software can read that ID before it strikes start. A datapath stub takes requests from the head of the queue over a valid/ready pair and later returns completion events tagged with the ID.

Completions are gathered into a 32-bit bitmap with one bit per ID. Two interrupt events are kept in sticky pending bits: a request taken by the datapath, which frees a slot, and a request finished. Each event can be masked. Optional features are chosen by parameters. When a feature is left out, its register reads back zero, so software can probe for it.

The register offsets are part of the software contract and are fixed: 0x080 mask, 0x084 pending, 0x088 visible source, 0x400 control, 0x404 next ID, 0x408 start, 0x40C flags, 0x410 destination, 0x414 source, 0x418 row length, 0x41C row count, 0x420 destination stride, 0x424 source stride, 0x428 done bitmap.

Top module: `dma_xfer_queue`

## Requirements
- R1: After reset the following read zero: control, next ID, start, done bitmap and pending. The mask reads 3 (both events blocked). `irq` and `req_valid` are low.
- R2: Writing 1 to bit 0 of the start register while the engine is enabled and the queue is not full stores the programmed request tagged with the current next ID. The next ID then advances by one and wraps from 31 to 0. `req_data` packs, MSB first: id[4:0], flags[2:0], dst[31:0], src[31:0], xlen[23:0], ylen[23:0], dst_stride[23:0], src_stride[23:0].
- R3: The start register reads 1 while the queue holds QDEPTH requests. A start strike in that state is dropped and leaves the next ID unchanged.
- R4: `req_valid` is high only when control bit 0 (enable) is set, control bit 1 (pause) is clear and the queue is not empty. Requests leave in the order they were stored.
- R5: Clearing the enable bit empties the queue. A start strike while the engine is disabled is dropped, and the next ID stays as it was.
- R6: Pending bit 0 sets on every `req_valid`/`req_ready` handshake. Pending bit 1 sets on every `cpl_valid`. Writing 1s to the pending register clears those bits. An event in the same cycle as a clear wins.
- R7: A mask bit of 1 blocks its event. The source register reads pending AND NOT mask, and `irq` is high exactly when that value is nonzero.
- R8: A completion for ID n sets bit n of the done register. Reading the done register clears the whole bitmap. Storing a new request with ID n clears bit n.
- R9: A completion with `cpl_partial` high also sets done bit 31 until the next read of the done register. Bit 31 is therefore shared by ID 31 and the partial-report flag.
- R10: With HAS_CYCLIC=0 the flags register drops bit 0. With HAS_2D=0 the row count and strides read 0. With HAS_DST_MEM=0 or HAS_SRC_MEM=0 the matching address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (needed for read side effects) |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | Interrupt, OR of unmasked pending bits |
| req_valid | output | 1 | Head request available for the datapath |
| req_ready | input | 1 | Datapath accepts the head request |
| req_data | output | 168 | Packed head request, layout in R2 |
| cpl_valid | input | 1 | Completion event |
| cpl_id | input | 5 | ID of the completed request |
| cpl_partial | input | 1 | Completion ended early |

## Verification
The assertions assume completion events name an ID that was handed out. They also assume the datapath never completes an ID in the same cycle that a fresh start reissues it; the done-bit property excludes that one cycle. The stimulus keeps completions as single-cycle pulses on IDs the bench chose, and never overlaps a completion with a start that reuses its ID. Handshakes and completions are otherwise free to coincide with register accesses, and one deliberate overlap of a pending clear with an event exercises the set-wins rule.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int ID_W   = 5;
    localparam int NID    = 1 << ID_W;
    localparam int RA_W   = 12;
    localparam int FLAG_W = 3;
    localparam int NEV    = 2;

    // event positions in the pending / mask words
    localparam int EV_SOT = 0;
    localparam int EV_EOT = 1;

    // flag bit positions
    localparam int F_CYCLIC  = 0;
    localparam int F_LAST    = 1;
    localparam int F_PARTIAL = 2;

    localparam logic [RA_W-1:0] A_IRQ_MASK = 12'h080;
    localparam logic [RA_W-1:0] A_IRQ_PEND = 12'h084;
    localparam logic [RA_W-1:0] A_IRQ_SRC  = 12'h088;
    localparam logic [RA_W-1:0] A_CTRL     = 12'h400;
    localparam logic [RA_W-1:0] A_NEXT_ID  = 12'h404;
    localparam logic [RA_W-1:0] A_START    = 12'h408;
    localparam logic [RA_W-1:0] A_FLAGS    = 12'h40C;
    localparam logic [RA_W-1:0] A_DST      = 12'h410;
    localparam logic [RA_W-1:0] A_SRC      = 12'h414;
    localparam logic [RA_W-1:0] A_XLEN     = 12'h418;
    localparam logic [RA_W-1:0] A_YLEN     = 12'h41C;
    localparam logic [RA_W-1:0] A_DSTRIDE  = 12'h420;
    localparam logic [RA_W-1:0] A_SSTRIDE  = 12'h424;
    localparam logic [RA_W-1:0] A_DONE     = 12'h428;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [LEN_W-1:0]  xlen;
        logic [LEN_W-1:0]  ylen;
        logic [LEN_W-1:0]  dstride;
        logic [LEN_W-1:0]  sstride;
    } xfer_req_t;

    localparam int REQ_W = $bits(xfer_req_t);

    function automatic logic [31:0] zext_len(input logic [LEN_W-1:0] v);
        return {{(32-LEN_W){1'b0}}, v};
    endfunction

    function automatic logic [NEV-1:0] visible_events(input logic [NEV-1:0] pend,
                                                      input logic [NEV-1:0] mask);
        return pend & ~mask;
    endfunction
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout  = slots[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq
    import dmaq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] set_ev,
    input  logic           clr_wr,
    input  logic [NEV-1:0] clr_bits,
    input  logic           mask_wr,
    input  logic [NEV-1:0] mask_bits,
    output logic [NEV-1:0] pending,
    output logic [NEV-1:0] mask,
    output logic           irq
);
    logic [NEV-1:0] clr_now;
    assign clr_now = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            mask    <= '1;
        end else begin
            if (mask_wr) mask <= mask_bits;
            pending <= (pending & ~clr_now) | set_ev;
        end
    end

    assign irq = |visible_events(pending, mask);
endmodule

// File: rtl/dmaq_done.sv
module dmaq_done
    import dmaq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cpl_valid,
    input  logic [ID_W-1:0] cpl_id,
    input  logic            cpl_partial,
    input  logic            rd_clear,
    input  logic            reuse,
    input  logic [ID_W-1:0] reuse_id,
    output logic [NID-1:0]  bitmap,
    output logic            partial
);
    logic [NID-1:0] nxt;

    for (genvar g = 0; g < NID; g++) begin : g_bit
        logic hit, drop;
        assign hit    = cpl_valid && (cpl_id == ID_W'(g));
        assign drop   = rd_clear || (reuse && (reuse_id == ID_W'(g)));
        assign nxt[g] = hit | (bitmap[g] & ~drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bitmap  <= '0;
            partial <= 1'b0;
        end else begin
            bitmap  <= nxt;
            partial <= (cpl_valid && cpl_partial) | (partial & ~rd_clear);
        end
    end
endmodule

// File: rtl/dma_xfer_queue.sv
module dma_xfer_queue
    import dmaq_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter bit HAS_CYCLIC  = 1'b1,
    parameter bit HAS_2D      = 1'b1,
    parameter bit HAS_DST_MEM = 1'b1,
    parameter bit HAS_SRC_MEM = 1'b1,
    localparam int CW         = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [31:0]      rd_data,
    output logic             irq,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [REQ_W-1:0] req_data,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_id,
    input  logic             cpl_partial
);
    logic              ctrl_en, ctrl_pause;
    logic [ID_W-1:0]   next_id;
    xfer_req_t         staged, q_head;
    logic [CW-1:0]     q_count;
    logic              q_full, q_empty;
    logic              push, pop;
    logic [NEV-1:0]    irq_pend, irq_mask, ev;
    logic [NID-1:0]    done_map;
    logic              done_partial;
    logic [31:0]       done_word;

    // ---------------- register file ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en    <= 1'b0;
            ctrl_pause <= 1'b0;
            staged     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl_en    <= wr_data[0];
                    ctrl_pause <= wr_data[1];
                end
                A_FLAGS: begin
                    staged.flags[F_CYCLIC]  <= HAS_CYCLIC ? wr_data[F_CYCLIC] : 1'b0;
                    staged.flags[F_LAST]    <= wr_data[F_LAST];
                    staged.flags[F_PARTIAL] <= wr_data[F_PARTIAL];
                end
                A_DST:     staged.dst     <= HAS_DST_MEM ? wr_data : '0;
                A_SRC:     staged.src     <= HAS_SRC_MEM ? wr_data : '0;
                A_XLEN:    staged.xlen    <= wr_data[LEN_W-1:0];
                A_YLEN:    staged.ylen    <= HAS_2D ? wr_data[LEN_W-1:0] : '0;
                A_DSTRIDE: staged.dstride <= HAS_2D ? wr_data[LEN_W-1:0] : '0;
                A_SSTRIDE: staged.sstride <= HAS_2D ? wr_data[LEN_W-1:0] : '0;
                default: ;
            endcase
        end
    end

    // ---------------- ID allocation and queue ----------------
    assign push = wr_en && (wr_addr == A_START) && wr_data[0] && ctrl_en && !q_full;

    always_ff @(posedge clk) begin
        if (rst)       next_id <= '0;
        else if (push) next_id <= next_id + 1'b1;
    end

    xfer_req_t q_in;
    always_comb begin
        q_in    = staged;
        q_in.id = next_id;
    end

    logic [REQ_W-1:0] q_out;

    dmaq_fifo #(.DEPTH(QDEPTH), .W(REQ_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (!ctrl_en),
        .push  (push),
        .din   (q_in),
        .pop   (pop),
        .dout  (q_out),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    assign q_head    = xfer_req_t'(q_out);
    assign req_valid = ctrl_en && !ctrl_pause && !q_empty;
    assign pop       = req_valid && req_ready;
    assign req_data  = q_head;

    // ---------------- interrupts ----------------
    always_comb begin
        ev         = '0;
        ev[EV_SOT] = pop;
        ev[EV_EOT] = cpl_valid;
    end

    dmaq_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_ev    (ev),
        .clr_wr    (wr_en && (wr_addr == A_IRQ_PEND)),
        .clr_bits  (wr_data[NEV-1:0]),
        .mask_wr   (wr_en && (wr_addr == A_IRQ_MASK)),
        .mask_bits (wr_data[NEV-1:0]),
        .pending   (irq_pend),
        .mask      (irq_mask),
        .irq       (irq)
    );

    // ---------------- completion tracking ----------------
    dmaq_done u_done (
        .clk         (clk),
        .rst         (rst),
        .cpl_valid   (cpl_valid),
        .cpl_id      (cpl_id),
        .cpl_partial (cpl_partial),
        .rd_clear    (rd_en && (rd_addr == A_DONE)),
        .reuse       (push),
        .reuse_id    (next_id),
        .bitmap      (done_map),
        .partial     (done_partial)
    );

    always_comb begin
        done_word     = 32'(done_map);
        done_word[31] = done_word[31] | done_partial;
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_IRQ_MASK: rd_data = 32'(irq_mask);
            A_IRQ_PEND: rd_data = 32'(irq_pend);
            A_IRQ_SRC:  rd_data = 32'(visible_events(irq_pend, irq_mask));
            A_CTRL:     rd_data = {30'b0, ctrl_pause, ctrl_en};
            A_NEXT_ID:  rd_data = 32'(next_id);
            A_START:    rd_data = {31'b0, q_full};
            A_FLAGS:    rd_data = 32'(staged.flags);
            A_DST:      rd_data = staged.dst;
            A_SRC:      rd_data = staged.src;
            A_XLEN:     rd_data = zext_len(staged.xlen);
            A_YLEN:     rd_data = zext_len(staged.ylen);
            A_DSTRIDE:  rd_data = zext_len(staged.dstride);
            A_SSTRIDE:  rd_data = zext_len(staged.sstride);
            A_DONE:     rd_data = done_word;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_xfer_queue_chk.sv
module dma_xfer_queue_chk
    import dmaq_pkg::*;
#(
    parameter int QDEPTH = 4,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            push,
    input logic [ID_W-1:0] next_id,
    input logic [CW-1:0]   q_count,
    input logic            ctrl_en,
    input logic            ctrl_pause,
    input logic            req_valid,
    input logic            req_ready,
    input logic            cpl_valid,
    input logic [ID_W-1:0] cpl_id,
    input logic [NEV-1:0]  irq_pend,
    input logic            irq,
    input logic [NID-1:0]  done_map
);
    AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        push |=> next_id == ID_W'($past(next_id) + 1'b1)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (q_count == CW'(QDEPTH)) |-> !push); // R3

    AST_VALID_GATED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (ctrl_en && !ctrl_pause && q_count != '0)); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> q_count == '0); // R5

    AST_SOT_SET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> irq_pend[EV_SOT]); // R6

    AST_EOT_SET: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> irq_pend[EV_EOT]); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_pend != '0)); // R7

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !(push && next_id == cpl_id)) |=> done_map[$past(cpl_id)]); // R8
endmodule

bind dma_xfer_queue dma_xfer_queue_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .next_id    (next_id),
    .q_count    (q_count),
    .ctrl_en    (ctrl_en),
    .ctrl_pause (ctrl_pause),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cpl_valid  (cpl_valid),
    .cpl_id     (cpl_id),
    .irq_pend   (irq_pend),
    .irq        (irq),
    .done_map   (done_map)
);

// File: tb/tb_dma_xfer_queue.sv
module tb_dma_xfer_queue;
    import dmaq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]      wr_addr = '0, rd_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data, rd_data_min;
    logic             irq, irq_min;
    logic             req_valid, req_valid_min;
    logic             req_ready = 1'b0;
    logic [REQ_W-1:0] req_data, req_data_min;
    logic             cpl_valid = 1'b0, cpl_partial = 1'b0;
    logic [4:0]       cpl_id = '0;

    int n_cmp = 0, n_bad = 0, cyc = 0, cap_n = 0;
    logic [4:0]  cap_id [64];
    logic [23:0] cap_x  [64];
    logic [31:0] got, got_min;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    dma_xfer_queue dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_partial(cpl_partial)
    );

    dma_xfer_queue #(.HAS_CYCLIC(1'b0), .HAS_2D(1'b0), .HAS_DST_MEM(1'b0), .HAS_SRC_MEM(1'b0)) dut_min (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_min), .irq(irq_min),
        .req_valid(req_valid_min), .req_ready(1'b1), .req_data(req_data_min),
        .cpl_valid(1'b0), .cpl_id(5'd0), .cpl_partial(1'b0)
    );

    function automatic logic [4:0] f_id(input logic [REQ_W-1:0] d);
        return d[REQ_W-1 -: 5];
    endfunction
    function automatic logic [23:0] f_xlen(input logic [REQ_W-1:0] d);
        return d[95:72];
    endfunction

    always @(posedge clk) begin
        if (!rst && req_valid && req_ready && cap_n < 64) begin
            cap_id[cap_n] = f_id(req_data);
            cap_x[cap_n]  = f_xlen(req_data);
            cap_n++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk); rd_addr = a; rd_en = 1'b1;
        #1 got = rd_data; got_min = rd_data_min;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic cpl(input logic [4:0] id, input logic part);
        @(negedge clk); cpl_valid = 1'b1; cpl_id = id; cpl_partial = part;
        @(posedge clk); #1 cpl_valid = 1'b0; cpl_partial = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CTRL);     chk("R1 ctrl", got, 0);
        rd(A_NEXT_ID);  chk("R1 next id", got, 0);
        rd(A_START);    chk("R1 start", got, 0);
        rd(A_DONE);     chk("R1 done", got, 0);
        rd(A_IRQ_PEND); chk("R1 pending", got, 0);
        rd(A_IRQ_MASK); chk("R1 mask", got, 3);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 req_valid", {31'b0, req_valid}, 0);

        // R10 feature probing
        wr(A_FLAGS, 32'h7);
        wr(A_YLEN, 32'd5);
        wr(A_DST, 32'h000ABCD0);
        wr(A_SRC, 32'h00001234);
        rd(A_FLAGS); chk("R10 flags full", got, 7); chk("R10 flags min", got_min, 6);
        rd(A_YLEN);  chk("R10 ylen full", got, 5); chk("R10 ylen min", got_min, 0);
        rd(A_DST);   chk("R10 dst full", got, 32'h000ABCD0); chk("R10 dst min", got_min, 0);
        rd(A_SRC);   chk("R10 src full", got, 32'h00001234); chk("R10 src min", got_min, 0);

        // R3 / R4 fill while paused
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 4; i++) begin
            wr(A_XLEN, 32'(100 + i));
            wr(A_START, 32'h1);
        end
        chk("R4 paused no valid", {31'b0, req_valid}, 0);
        rd(A_NEXT_ID); chk("R2 next id after 4", got, 4);
        rd(A_START);   chk("R3 full flag", got, 1);
        wr(A_XLEN, 32'd200);
        wr(A_START, 32'h1);
        rd(A_NEXT_ID); chk("R3 dropped start", got, 4);
        wr(A_CTRL, 32'h1);
        chk("R4 valid after unpause", {31'b0, req_valid}, 1);
        chk("R4 head id", 32'(f_id(req_data)), 0);
        chk("R2 head xlen", 32'(f_xlen(req_data)), 100);
        @(negedge clk) req_ready = 1'b1;
        repeat (8) @(posedge clk);
        #1 chk("R4 drained count", cap_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 order id", 32'(cap_id[i]), i);
            chk("R4 order xlen", 32'(cap_x[i]), 100 + i);
        end
        rd(A_IRQ_PEND); chk("R6 sot pending", got, 1);
        wr(A_IRQ_PEND, 32'h3);
        rd(A_IRQ_PEND); chk("R6 cleared", got, 0);

        // R2 sweep across the ID wrap
        for (int k = 4; k < 40; k++) begin
            wr(A_XLEN, 32'(k));
            wr(A_START, 32'h1);
        end
        repeat (4) @(posedge clk);
        #1 chk("R2 sweep count", cap_n, 40);
        for (int k = 4; k < 40; k++) begin
            chk("R2 sweep id", 32'(cap_id[k]), k % 32);
            chk("R2 sweep xlen", 32'(cap_x[k]), k);
        end
        rd(A_NEXT_ID); chk("R2 wrapped next id", got, 8);

        // R6 / R7 completion interrupts
        wr(A_IRQ_PEND, 32'h3);
        wr(A_IRQ_MASK, 32'h0);
        cpl(5'd5, 1'b0);
        rd(A_IRQ_PEND); chk("R6 eot pending", got, 2);
        rd(A_IRQ_SRC);  chk("R7 source", got, 2);
        chk("R7 irq high", {31'b0, irq}, 1);
        wr(A_IRQ_MASK, 32'h2);
        chk("R7 irq masked", {31'b0, irq}, 0);
        rd(A_IRQ_SRC);  chk("R7 source masked", got, 0);
        rd(A_DONE); chk("R8 done id5", got, 32'h20);
        rd(A_DONE); chk("R8 clear on read", got, 0);

        // R8 every ID position
        for (int n = 0; n < 32; n++) begin
            cpl(5'(n), 1'b0);
            rd(A_DONE); chk("R8 done bit sweep", got, 32'h1 << n);
        end

        // R8 reuse clears
        cpl(5'd9, 1'b0);
        wr(A_START, 32'h1);
        wr(A_START, 32'h1);
        rd(A_DONE); chk("R8 reuse clears", got, 0);

        // R6 set wins over clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_IRQ_PEND; wr_data = 32'h3;
        cpl_valid = 1'b1; cpl_id = 5'd1;
        @(posedge clk); #1 wr_en = 1'b0; cpl_valid = 1'b0;
        rd(A_IRQ_PEND); chk("R6 set wins", got, 2);
        rd(A_DONE); chk("R8 done id1", got, 2);

        // R9 partial flag
        cpl(5'd3, 1'b1);
        rd(A_DONE); chk("R9 partial", got, 32'h80000008);
        rd(A_DONE); chk("R9 partial cleared", got, 0);

        // R5 abort
        @(negedge clk) req_ready = 1'b0;
        for (int i = 0; i < 3; i++) wr(A_START, 32'h1);
        chk("R5 valid before abort", {31'b0, req_valid}, 1);
        chk("R5 head id", 32'(f_id(req_data)), 10);
        wr(A_CTRL, 32'h0);
        chk("R5 valid after abort", {31'b0, req_valid}, 0);
        rd(A_NEXT_ID); chk("R5 next id", got, 13);
        wr(A_START, 32'h1);
        rd(A_NEXT_ID); chk("R5 disabled start dropped", got, 13);
        wr(A_CTRL, 32'h1);
        chk("R5 queue emptied", {31'b0, req_valid}, 0);
        rd(A_START); chk("R5 not full", got, 0);

        done_flag = 1;
        summary();
    end
endmodule